// File: doc/BRIEF.md
# Scan Test Sequencing Controller

This block holds a parameterised row of scan flip-flops wired as one serial chain. It also holds the controller that steps that chain through a complete test pattern. A placeholder combinational network sits in front of the cells. It stands in for the logic under test: each cell's functional next value is the XOR of one bit of the functional input vector and the cell's upstream neighbour (wrapping from the last cell to the first). A one-cycle start strobe in the idle state begins a pattern. The chain then shifts for exactly as many cycles as it has cells. During that shift each new stimulus bit enters at the scan input, and the response left by the previous pattern leaves at the scan output. The controller then fires capture enables according to the test mode latched with the strobe.

Three timing modes are offered. The stuck-at mode uses a slow capture with one settling cycle between load and capture. In the launch-off-shift mode the final shift launches the transition and the capture follows at once. In the launch-off-capture mode two captures run back to back with scan enable low, so the second capture observes the transition launched by the first. A single-cycle done pulse marks the end of each pattern. The captured response is then unloaded by the next pattern's shift, or by a dummy one.

Top module: `scan_seq_ctrl`

## Requirements
- R1: After reset, scan_en, cap_en, busy and done are low and every chain cell holds 0, so the first unload after reset yields only zeros.
- R2: A start strobe sampled while idle makes scan_en high in the next cycle, and it stays high for exactly CHAIN_LEN consecutive cycles.
- R3: During a shift cycle, cell 0 takes scan_in, every other cell takes its lower neighbour, and scan_out always shows the highest cell. The bits leaving during a load are therefore the previous contents, highest cell first. Stimulus for cell i must be shifted in at position CHAIN_LEN-1-i of the bit sequence.
- R4: On a capture cycle, cell i loads func_in[i] XOR cell ((i+1) mod CHAIN_LEN).
- R5: Mode code 0 selects stuck-at: after the shift there is one cycle with scan_en and cap_en both low, then one capture cycle. Code 3 behaves the same way.
- R6: Mode code 1 selects launch-off-shift: the cycle right after the last shift is the single capture cycle.
- R7: Mode code 2 selects launch-off-capture: two consecutive capture cycles follow the shift with scan_en low in both, and the second capture works on the result of the first.
- R8: done is high for exactly one cycle, the cycle after the final capture. busy is low in that same cycle.
- R9: A start strobe while busy is ignored, and mode and func_in changes after the strobe do not alter the running pattern's timing. The mode is latched at the strobe.
- R10: scan_en and cap_en are never high together, and the chain holds its contents in any cycle where neither is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pattern start strobe |
| mode | input | 2 | Test mode code (0 stuck-at, 1 launch-off-shift, 2 launch-off-capture, 3 as 0) |
| func_in | input | CHAIN_LEN | Functional input vector to the placeholder logic |
| scan_in | input | 1 | Serial scan data in |
| scan_en | output | 1 | Chain in shift mode |
| cap_en | output | 1 | Capture enable for the cells |
| busy | output | 1 | Pattern in progress |
| done | output | 1 | One-cycle end-of-pattern pulse |
| scan_out | output | 1 | Serial scan data out (highest cell) |

## Verification
The bench builds the block with CHAIN_LEN set to 5. The odd length keeps each pattern short and still exercises the wrap from the last cell back to cell 0 in the capture function. The length also exercises a shift counter that does not end on a power of two. At this size, every mode code, back-to-back patterns and a stray strobe in the middle of a shift fit into a few hundred cycles. Every unload bit is compared against a bench model of the chain.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
   typedef enum logic [1:0] {
      TM_STUCK = 2'd0,
      TM_LOS   = 2'd1,
      TM_LOC   = 2'd2
   } test_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SHIFT = 3'd1,
      ST_GAP   = 3'd2,
      ST_CAP1  = 3'd3,
      ST_CAP2  = 3'd4
   } seq_state_e;

   function automatic test_mode_e decode_mode(input logic [1:0] code);
      case (code)
         2'd1:    return TM_LOS;
         2'd2:    return TM_LOC;
         default: return TM_STUCK;
      endcase
   endfunction
endpackage

// File: rtl/scan_cut.sv
module scan_cut #(
   parameter int CHAIN_LEN = 8
) (
   input  logic [CHAIN_LEN-1:0] state_q,
   input  logic [CHAIN_LEN-1:0] pin,
   output logic [CHAIN_LEN-1:0] nxt
);
   for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_bit
      localparam int UP = (i + 1) % CHAIN_LEN;
      assign nxt[i] = pin[i] ^ state_q[UP];
   end
endmodule

// File: rtl/scan_cell_chain.sv
module scan_cell_chain #(
   parameter int CHAIN_LEN = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift_en,
   input  logic                 capt_en,
   input  logic                 ser_in,
   input  logic [CHAIN_LEN-1:0] d,
   output logic [CHAIN_LEN-1:0] q
);
   for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
      logic prev;
      if (i == 0) begin : g_head
         assign prev = ser_in;
      end else begin : g_body
         assign prev = q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q[i] <= 1'b0;
         else if (shift_en) q[i] <= prev;
         else if (capt_en)  q[i] <= d[i];
      end
   end

   // R3
   shift_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (q[0] == $past(ser_in)) && (q[CHAIN_LEN-1] == $past(q[CHAIN_LEN-2])));
   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !capt_en) |=> $stable(q));
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
   import scan_seq_pkg::*;
#(
   parameter int CHAIN_LEN = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] mode,
   output logic       scan_en,
   output logic       cap_en,
   output logic       busy,
   output logic       done
);
   localparam int CNT_W = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

   seq_state_e       st_q, st_d;
   test_mode_e       mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic             final_cap;

   assign final_cap = (st_q == ST_CAP2) ||
                      (st_q == ST_CAP1 && mode_q != TM_LOC);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (start) st_d = ST_SHIFT;
         ST_SHIFT: if (cnt_q == LAST)
                      st_d = (mode_q == TM_STUCK) ? ST_GAP : ST_CAP1;
         ST_GAP:   st_d = ST_CAP1;
         ST_CAP1:  st_d = (mode_q == TM_LOC) ? ST_CAP2 : ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mode_q <= TM_STUCK;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= final_cap;
         if (st_q == ST_IDLE && start) mode_q <= decode_mode(mode);
         if (st_q == ST_SHIFT) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   assign scan_en = (st_q == ST_SHIFT);
   assign cap_en  = (st_q == ST_CAP1) || (st_q == ST_CAP2);
   assign busy    = (st_q != ST_IDLE);
   assign done    = done_q;

   // R10
   excl_en_chk: assert property (@(posedge clk) disable iff (!rst_n) !(scan_en && cap_en));
   // R2
   start_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> scan_en);
   // R5
   stuck_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scan_en) && mode_q == TM_STUCK) |-> !cap_en);
   // R6
   los_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scan_en) && mode_q == TM_LOS) |-> cap_en);
   // R7
   loc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cap_en) && mode_q == TM_LOC) |=> (cap_en && !scan_en));
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl #(
   parameter int CHAIN_LEN = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [1:0]           mode,
   input  logic [CHAIN_LEN-1:0] func_in,
   input  logic                 scan_in,
   output logic                 scan_en,
   output logic                 cap_en,
   output logic                 busy,
   output logic                 done,
   output logic                 scan_out
);
   if (CHAIN_LEN < 2) begin : g_len_bad
      $error("scan_seq_ctrl: CHAIN_LEN must be at least 2");
   end

   logic [CHAIN_LEN-1:0] cell_q;
   logic [CHAIN_LEN-1:0] cut_nxt;

   scan_seq_fsm #(.CHAIN_LEN(CHAIN_LEN)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .scan_en(scan_en), .cap_en(cap_en), .busy(busy), .done(done)
   );

   scan_cut #(.CHAIN_LEN(CHAIN_LEN)) u_cut (
      .state_q(cell_q), .pin(func_in), .nxt(cut_nxt)
   );

   scan_cell_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
      .clk(clk), .rst_n(rst_n), .shift_en(scan_en), .capt_en(cap_en),
      .ser_in(scan_in), .d(cut_nxt), .q(cell_q)
   );

   assign scan_out = cell_q[CHAIN_LEN-1];

   // R4
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> cell_q == ($past(func_in) ^ {$past(cell_q[0]), $past(cell_q[CHAIN_LEN-1:1])}));
endmodule

// File: tb/scan_seq_ctrl_tb.sv
module scan_seq_ctrl_tb;
   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic [N-1:0] func_in = '0;
   logic         scan_in = 1'b0;
   logic         scan_en, cap_en, busy, done, scan_out;

   int checks = 0;
   int errors = 0;
   logic [N-1:0] model = '0;
   logic         exp_q[$];

   always #2.5 clk = ~clk;

   scan_seq_ctrl #(.CHAIN_LEN(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .func_in(func_in),
      .scan_in(scan_in), .scan_en(scan_en), .cap_en(cap_en), .busy(busy),
      .done(done), .scan_out(scan_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] cut(input logic [N-1:0] s, input logic [N-1:0] f);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) r[i] = f[i] ^ s[(i + 1) % N];
      return r;
   endfunction

   // monitor: every shift cycle pops one expected unload bit (R3)
   always @(negedge clk) begin
      if (rst_n && scan_en) begin
         if (exp_q.size() == 0) begin
            chk("R3 unexpected shift", 1, 0);
         end else begin
            chk("R3 unload bit", scan_out, exp_q.pop_front());
         end
      end
   end

   task automatic run_pattern(input logic [N-1:0] pat, input logic [N-1:0] fi,
                              input logic [1:0] md, input bit stray);
      logic [N-1:0] fi_used = fi;
      @(negedge clk);
      for (int i = N - 1; i >= 0; i--) exp_q.push_back(model[i]);
      start = 1'b1; mode = md; func_in = fi;
      @(negedge clk);
      start = 1'b0;
      for (int j = 0; j < N; j++) begin
         chk("R2 scan_en during shift", scan_en, 1);
         chk("R10 no capture in shift", cap_en, 0);
         scan_in = pat[N-1-j];
         if (stray && j == 2) begin
            start = 1'b1; mode = 2'd2;   // R9 ignored while busy
         end
         @(negedge clk);
         start = 1'b0;
      end
      mode = md;
      chk("R2 scan_en low after N shifts", scan_en, 0);
      model = pat;
      if (md == 2'd1) begin
         chk("R6 capture right after shift", cap_en, 1);
         model = cut(model, fi_used);
         @(negedge clk);
      end else if (md == 2'd2) begin
         chk("R7 first capture", cap_en, 1);
         model = cut(model, fi_used);
         @(negedge clk);
         chk("R7 second capture", cap_en, 1);
         chk("R7 scan_en low", scan_en, 0);
         model = cut(model, fi_used);
         @(negedge clk);
      end else begin
         chk("R5 idle gap", {scan_en, cap_en}, 2'b00);
         @(negedge clk);
         chk("R5 single capture", cap_en, 1);
         model = cut(model, fi_used);
         @(negedge clk);
      end
      chk("R8 done pulse", done, 1);
      chk("R8 busy low with done", busy, 0);
      chk("R8 no extra capture", cap_en, 0);
      @(negedge clk);
      chk("R8 done one cycle", done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset scan_en", scan_en, 0);
      chk("R1 reset cap_en", cap_en, 0);
      chk("R1 reset busy", busy, 0);
      chk("R1 reset done", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle holds", busy, 0);
      run_pattern(5'b10110, 5'b01101, 2'd0, 0);   // R1 zeros unload, R5
      run_pattern(5'b01011, 5'b11100, 2'd1, 0);   // R6
      run_pattern(5'b11001, 5'b00111, 2'd2, 0);   // R7
      run_pattern(5'b00110, 5'b10001, 2'd3, 0);   // R5 code 3
      run_pattern(5'b11111, 5'b01010, 2'd1, 1);   // R9
      repeat (4) @(negedge clk);
      chk("R10 idle no enables", {scan_en, cap_en}, 2'b00);
      run_pattern(5'b10000, 5'b00000, 2'd2, 0);   // R4 wrap, R10 held idle
      run_pattern(5'b00000, 5'b00000, 2'd0, 0);   // flush last response
      chk("R3 queue drained", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule